// File: doc/BRIEF.md
# Clock Mode Stop/Exit Controller

This block follows the operating mode of a clock generator from the selection fields that software writes to it. Those fields choose the output source (FLL or PLL engaged, internal reference bypass, external reference bypass), the reference and a low-power bypass. From them the block works out the active mode, the clock-status code and the enables for the FLL, the PLL and the internal reference clock. Oscillators and loops are not modelled. The block sees the PLL loop only as a lock input and drives an enable for each clock.

A reference change does not take effect at once. The status bit follows the selected reference only after a configurable settling count. When the reference changes while an FLL-engaged mode is active, the FLL lock flag drops and comes back after a relock count.

The block also handles stop. On entry it gates the clocks according to the stop kind and the stop-enable bits, and it keeps the pre-stop mode. On exit it either resumes that mode or forces a bypass mode. When it forces one, it rewrites the select field and the status field, can clear the PLL stop-enable, and clears the PLL lock flag without raising loss-of-lock.

Top module: `clkmode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the FLL-engaged-internal mode. In that state mode is 0, select is 2'b00, clock-status is 2'b00, reference-status is 1, PLL lock is 0 and loss-of-lock is 0.
- R2: Mode codes are FEI=0, FEE=1, FBI=2, FBE=3, BLPI=4, BLPE=5, PBE=6, PEE=7, PEI=8 and STOP=9. Status codes are 00 for FLL output, 01 for internal reference, 10 for external reference and 11 for PLL output. The mode is decoded from the written fields one cycle after the write edge:
  - select 00 gives PEE or PEI when PLL-select is 1, otherwise FEE or FEI, with the internal variant when reference-status is 1;
  - select 01 gives BLPI when the low-power bit is 1, otherwise FBI;
  - select 10 gives BLPE when the low-power bit is 1, otherwise PBE when PLL-select is 1, otherwise FBE.
- R3: Reference-status takes the value of reference-select exactly `REF_SW_CYC` cycles after the write. In an FLL-engaged mode, the FLL lock flag falls in that same cycle and rises again `FLL_LOCK_CYC` cycles later.
- R4: In BLPI and BLPE both the FLL and the PLL enables are 0, even when the PLL clock-enable bit is 1.
- R5: In any stop the mode output reads STOP (9) and the FLL enable is 0. Normal stop (kind 00) keeps the PLL enable equal to PLL stop-enable. It also keeps the internal-reference enable at 1 when both the internal-reference enable and its stop-enable are 1.
- R6: In LLS stop (kind 01) every clock enable is 0. In VLPS stop (kind 10) the internal-reference enable is 1 only when its enable, its stop-enable and the fast-select bit are all 1.
- R7: On exit from LLS or VLPS entered from PEE, the block forces mode PBE, select 10 and status 10. It also sets PLL stop-enable to 0 and PLL lock to 0, and leaves loss-of-lock at 0.
- R8: On exit from LLS or VLPS entered from PEI, the block forces select 01 and status 01, sets PLL stop-enable to 0 and clears PLL lock.
- R9: On exit from normal stop entered from PEE:
  - with PLL stop-enable 0, the block forces PBE with select 10 and status 10 and clears lock without raising loss-of-lock;
  - with PLL stop-enable 1, the mode stays PEE and lock stays 1.
- R10: The block ignores a configuration write during stop, ignores a stop request during stop, and ignores a wake outside stop.
- R11: While the PLL is enabled and the block is not in stop, PLL lock follows `pll_locked_i` one cycle later. A fall of the lock input while lock is 1 sets loss-of-lock. Loss-of-lock then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Write strobe for all configuration fields |
| cfg_clk_sel_i | input | 2 | Output source select |
| cfg_ref_sel_i | input | 1 | Reference select, 1 = internal |
| cfg_lp_i | input | 1 | Low-power bypass bit |
| cfg_pll_sel_i | input | 1 | PLL (1) or FLL (0) in engaged/bypass modes |
| cfg_pll_clken_i | input | 1 | Keep the PLL running outside PLL modes |
| cfg_pll_sten_i | input | 1 | PLL stop-enable |
| cfg_irc_en_i | input | 1 | Internal-reference clock enable |
| cfg_irc_sten_i | input | 1 | Internal-reference stop-enable |
| cfg_irc_fast_i | input | 1 | Fast internal reference select |
| stop_req_i | input | 1 | Stop entry request pulse |
| stop_kind_i | input | 2 | Stop kind: 00 normal, 01 LLS, 10 VLPS |
| wake_i | input | 1 | Stop exit pulse |
| pll_locked_i | input | 1 | Lock indication from the PLL loop |
| mode_o | output | 4 | Current mode code |
| clk_sel_o | output | 2 | Output source select as held |
| clk_st_o | output | 2 | Clock-status code |
| ref_st_o | output | 1 | Reference-status |
| pll_sten_o | output | 1 | PLL stop-enable as held |
| fll_en_o | output | 1 | FLL enable |
| fll_lock_o | output | 1 | FLL lock flag |
| pll_en_o | output | 1 | PLL enable |
| irclk_en_o | output | 1 | Internal-reference clock enable |
| pll_lock_o | output | 1 | PLL lock flag |
| pll_lol_o | output | 1 | Sticky PLL loss-of-lock flag |

## Verification
A wrong mode register shows up one cycle after the write edge that caused it: the mode code and the status code both read wrong, and the enables are wrong in the same cycle. A wrong pre-stop mode or stop kind stays hidden during stop except through the clock enables. It becomes visible on the exit edge, where the select field, the status field, the PLL stop-enable and the lock flag all read back different values. A fault in the reference-settling counter or the FLL relock counter moves the edge of the reference-status bit or of the FLL lock flag by whole cycles. The checks therefore sample in the exact cycle where each flag is due to change.

// File: rtl/clkmode_pkg.sv
// Shared types and decode functions for the clock mode controller.
// Assumes select code 2'b11 is reserved and leaves the mode unchanged.
package clkmode_pkg;

    typedef enum logic [3:0] {
        M_FEI  = 4'd0,
        M_FEE  = 4'd1,
        M_FBI  = 4'd2,
        M_FBE  = 4'd3,
        M_BLPI = 4'd4,
        M_BLPE = 4'd5,
        M_PBE  = 4'd6,
        M_PEE  = 4'd7,
        M_PEI  = 4'd8,
        M_STOP = 4'd9
    } mode_e;

    typedef enum logic [1:0] {
        STOP_NORMAL = 2'd0,
        STOP_LLS    = 2'd1,
        STOP_VLPS   = 2'd2,
        STOP_RSVD   = 2'd3
    } stop_e;

    localparam logic [1:0] SEL_ENGAGED = 2'b00;
    localparam logic [1:0] SEL_INT     = 2'b01;
    localparam logic [1:0] SEL_EXT     = 2'b10;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       ref_sel;
        logic       lp;
        logic       pll_sel;
        logic       pll_clken;
        logic       pll_sten;
        logic       irc_en;
        logic       irc_sten;
        logic       irc_fast;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{clk_sel: SEL_ENGAGED, ref_sel: 1'b1,
                                   default: 1'b0};

    // Mode implied by the select fields and the settled reference.
    function automatic mode_e decode_mode(input logic [1:0] sel, input logic ref_int,
                                          input logic lp, input logic pll_sel,
                                          input mode_e prev);
        mode_e m;
        case (sel)
            SEL_ENGAGED: m = pll_sel ? (ref_int ? M_PEI : M_PEE)
                                     : (ref_int ? M_FEI : M_FEE);
            SEL_INT:     m = lp ? M_BLPI : M_FBI;
            SEL_EXT:     m = lp ? M_BLPE : (pll_sel ? M_PBE : M_FBE);
            default:     m = prev;
        endcase
        return m;
    endfunction

    // Clock-status code shown for a run mode.
    function automatic logic [1:0] status_of(input mode_e m);
        logic [1:0] s;
        case (m)
            M_FEI, M_FEE:         s = 2'b00;
            M_FBI, M_BLPI:        s = 2'b01;
            M_FBE, M_BLPE, M_PBE: s = 2'b10;
            default:              s = 2'b11;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/clkmode_refsw.sv
// Reference switch tracker: the status bit follows the select bit after
// REF_SW_CYC consecutive cycles of disagreement. A pulse marks the switch.
// Assumes REF_SW_CYC >= 1; a select that flips back restarts the count.
module clkmode_refsw #(
    parameter int REF_SW_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_sel_i,
    output logic ref_st_o,
    output logic flip_o
);
    localparam int CW = $clog2(REF_SW_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(REF_SW_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          ref_st_q;

    assign flip_o   = (ref_sel_i != ref_st_q) && (cnt_q == LAST);
    assign ref_st_o = ref_st_q;

    // Count cycles of disagreement and adopt the new reference at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_st_q <= 1'b1;
            cnt_q    <= '0;
        end else if (ref_sel_i == ref_st_q) begin
            cnt_q <= '0;
        end else if (flip_o) begin
            ref_st_q <= ref_sel_i;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    // ref_settle_chk
    ref_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_st_q != $past(ref_st_q)) |-> ($past(ref_sel_i) == ref_st_q));

endmodule

// File: rtl/clkmode_fll_lock.sv
// FLL lock model: lock rises FLL_LOCK_CYC cycles after the FLL is enabled
// or after a reference switch restarts it; it drops while disabled.
// Assumes FLL_LOCK_CYC >= 1.
module clkmode_fll_lock #(
    parameter int FLL_LOCK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fll_en_i,
    input  logic flip_i,
    output logic fll_lock_o
);
    localparam int CW = $clog2(FLL_LOCK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FLL_LOCK_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          lock_q;

    assign fll_lock_o = lock_q;

    // Restart on reference switch or disable, then count up to lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else if (flip_i || !fll_en_i) begin
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!lock_q) begin
            if (cnt_q == LAST) lock_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R3
    // fll_off_unlock_chk
    fll_off_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fll_en_i |=> !lock_q);

    // R3
    // fll_relock_chk
    fll_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> ($past(fll_en_i) && !$past(flip_i)));

endmodule

// File: rtl/clkmode_gates.sv
// Output decode: mode code, clock status and clock enables from the held
// mode, the stop state and the configuration. Purely combinational.
// Assumes the stop kind is only meaningful while in stop.
module clkmode_gates
    import clkmode_pkg::*;
(
    input  mode_e      mode_q_i,
    input  logic       in_stop_i,
    input  stop_e      stop_kind_i,
    input  cfg_t       cfg_i,
    output logic [3:0] mode_o,
    output logic [1:0] clk_st_o,
    output logic       fll_en_o,
    output logic       pll_en_o,
    output logic       irclk_en_o
);
    logic is_blp;
    logic pll_mode;
    logic fll_mode;
    logic irc_keep;

    // Classify the held mode for the enable equations.
    always_comb begin
        is_blp   = (mode_q_i == M_BLPI) || (mode_q_i == M_BLPE);
        pll_mode = (mode_q_i == M_PBE) || (mode_q_i == M_PEE) || (mode_q_i == M_PEI);
        fll_mode = (mode_q_i == M_FEI) || (mode_q_i == M_FEE) ||
                   (mode_q_i == M_FBI) || (mode_q_i == M_FBE);
        irc_keep = cfg_i.irc_en && cfg_i.irc_sten;
    end

    // Select run-time or stop-time enables.
    always_comb begin
        mode_o   = in_stop_i ? 4'(M_STOP) : 4'(mode_q_i);
        clk_st_o = status_of(mode_q_i);
        if (in_stop_i) begin
            fll_en_o   = 1'b0;
            pll_en_o   = (stop_kind_i == STOP_NORMAL) && cfg_i.pll_sten;
            irclk_en_o = irc_keep && ((stop_kind_i == STOP_NORMAL) ||
                                      ((stop_kind_i == STOP_VLPS) && cfg_i.irc_fast));
        end else begin
            fll_en_o   = fll_mode;
            pll_en_o   = pll_mode || (cfg_i.pll_clken && !is_blp);
            irclk_en_o = cfg_i.irc_en;
        end
    end

endmodule

// File: rtl/clkmode_mode_fsm.sv
// Mode and stop sequencer: holds the configuration fields, the run mode,
// the stop state and the PLL lock flags, and applies the exit overrides.
// Assumes wake and stop requests are single-cycle pulses from the power
// controller; writes and requests arriving at the wrong time are dropped.
module clkmode_mode_fsm
    import clkmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_wr_i,
    input  cfg_t  cfg_i,
    input  logic  stop_req_i,
    input  stop_e stop_kind_i,
    input  logic  wake_i,
    input  logic  ref_st_i,
    input  logic  pll_en_i,
    input  logic  pll_locked_i,
    output cfg_t  cfg_o,
    output mode_e mode_q_o,
    output logic  in_stop_o,
    output stop_e stop_kind_o,
    output logic  pll_lock_o,
    output logic  pll_lol_o
);
    cfg_t  cfg_q;
    mode_e mode_q;
    logic  in_stop_q;
    stop_e kind_q;
    logic  lock_q;
    logic  lol_q;

    logic  exit_now;
    logic  enter_now;
    logic  low_stop;
    logic  force_ext;
    logic  force_int;

    // Work out entry, exit and which override the exit applies.
    always_comb begin
        exit_now  = in_stop_q && wake_i;
        enter_now = !in_stop_q && stop_req_i;
        low_stop  = (kind_q != STOP_NORMAL);
        force_ext = exit_now && (mode_q == M_PEE) && (low_stop || !cfg_q.pll_sten);
        force_int = exit_now && (mode_q == M_PEI) && low_stop;
    end

    // Configuration fields: software writes outside stop, overrides on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (force_ext) begin
            cfg_q.clk_sel <= SEL_EXT;
            if (low_stop) cfg_q.pll_sten <= 1'b0;
        end else if (force_int) begin
            cfg_q.clk_sel  <= SEL_INT;
            cfg_q.pll_sten <= 1'b0;
        end else if (cfg_wr_i && !in_stop_q) begin
            cfg_q <= cfg_i;
        end
    end

    // Run mode register: decoded while running, frozen in stop, forced on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_FEI;
        end else if (force_ext) begin
            mode_q <= decode_mode(SEL_EXT, ref_st_i, cfg_q.lp, cfg_q.pll_sel, mode_q);
        end else if (force_int) begin
            mode_q <= decode_mode(SEL_INT, ref_st_i, cfg_q.lp, cfg_q.pll_sel, mode_q);
        end else if (!in_stop_q) begin
            mode_q <= decode_mode(cfg_q.clk_sel, ref_st_i, cfg_q.lp, cfg_q.pll_sel, mode_q);
        end
    end

    // Stop state and the kind latched at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_stop_q <= 1'b0;
            kind_q    <= STOP_NORMAL;
        end else if (enter_now) begin
            in_stop_q <= 1'b1;
            kind_q    <= stop_kind_i;
        end else if (exit_now) begin
            in_stop_q <= 1'b0;
        end
    end

    // PLL lock flag: quiet clear on forced exit, frozen in stop, else tracks.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lock_q <= 1'b0;
        else if (force_ext || force_int) lock_q <= 1'b0;
        else if (in_stop_q)         lock_q <= lock_q;
        else if (!pll_en_i)         lock_q <= 1'b0;
        else                        lock_q <= pll_locked_i;
    end

    // Sticky loss-of-lock: lock drops while the PLL is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lol_q <= 1'b0;
        else if (!in_stop_q && pll_en_i && lock_q && !pll_locked_i)
            lol_q <= 1'b1;
    end

    assign cfg_o       = cfg_q;
    assign mode_q_o    = mode_q;
    assign in_stop_o   = in_stop_q;
    assign stop_kind_o = kind_q;
    assign pll_lock_o  = lock_q;
    assign pll_lol_o   = lol_q;

    // R7
    // quiet_exit_chk
    quiet_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop_q && wake_i) |=> (lol_q == $past(lol_q)));

    // R10
    // cfg_frozen_chk
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop_q && $past(in_stop_q)) |-> $stable(cfg_q));

    // R9
    // keep_lock_chk
    keep_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop_q && wake_i && (kind_q == STOP_NORMAL) && cfg_q.pll_sten)
            |=> (lock_q == $past(lock_q)));

endmodule

// File: rtl/clkmode_ctrl.sv
// Clock mode stop/exit controller top: ties the reference switch tracker,
// the FLL lock model, the mode sequencer and the output decode together.
// Assumes all inputs are synchronous to clk.
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int REF_SW_CYC   = 4,
    parameter int FLL_LOCK_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic [1:0] cfg_clk_sel_i,
    input  logic       cfg_ref_sel_i,
    input  logic       cfg_lp_i,
    input  logic       cfg_pll_sel_i,
    input  logic       cfg_pll_clken_i,
    input  logic       cfg_pll_sten_i,
    input  logic       cfg_irc_en_i,
    input  logic       cfg_irc_sten_i,
    input  logic       cfg_irc_fast_i,
    input  logic       stop_req_i,
    input  logic [1:0] stop_kind_i,
    input  logic       wake_i,
    input  logic       pll_locked_i,
    output logic [3:0] mode_o,
    output logic [1:0] clk_sel_o,
    output logic [1:0] clk_st_o,
    output logic       ref_st_o,
    output logic       pll_sten_o,
    output logic       fll_en_o,
    output logic       fll_lock_o,
    output logic       pll_en_o,
    output logic       irclk_en_o,
    output logic       pll_lock_o,
    output logic       pll_lol_o
);
    cfg_t  cfg_in;
    cfg_t  cfg_w;
    mode_e mode_q_w;
    stop_e kind_w;
    logic  in_stop_w;
    logic  ref_st_w;
    logic  flip_w;
    logic  fll_en_w;
    logic  fll_lock_w;
    logic  pll_en_w;
    logic  pll_lock_w;

    // Gather the write fields into one record.
    always_comb begin
        cfg_in.clk_sel   = cfg_clk_sel_i;
        cfg_in.ref_sel   = cfg_ref_sel_i;
        cfg_in.lp        = cfg_lp_i;
        cfg_in.pll_sel   = cfg_pll_sel_i;
        cfg_in.pll_clken = cfg_pll_clken_i;
        cfg_in.pll_sten  = cfg_pll_sten_i;
        cfg_in.irc_en    = cfg_irc_en_i;
        cfg_in.irc_sten  = cfg_irc_sten_i;
        cfg_in.irc_fast  = cfg_irc_fast_i;
    end

    clkmode_refsw #(.REF_SW_CYC(REF_SW_CYC)) u_refsw (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_sel_i (cfg_w.ref_sel),
        .ref_st_o  (ref_st_w),
        .flip_o    (flip_w)
    );

    clkmode_fll_lock #(.FLL_LOCK_CYC(FLL_LOCK_CYC)) u_fll (
        .clk        (clk),
        .rst_n      (rst_n),
        .fll_en_i   (fll_en_w),
        .flip_i     (flip_w),
        .fll_lock_o (fll_lock_w)
    );

    clkmode_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_i        (cfg_in),
        .stop_req_i   (stop_req_i),
        .stop_kind_i  (stop_e'(stop_kind_i)),
        .wake_i       (wake_i),
        .ref_st_i     (ref_st_w),
        .pll_en_i     (pll_en_w),
        .pll_locked_i (pll_locked_i),
        .cfg_o        (cfg_w),
        .mode_q_o     (mode_q_w),
        .in_stop_o    (in_stop_w),
        .stop_kind_o  (kind_w),
        .pll_lock_o   (pll_lock_w),
        .pll_lol_o    (pll_lol_o)
    );

    clkmode_gates u_gates (
        .mode_q_i    (mode_q_w),
        .in_stop_i   (in_stop_w),
        .stop_kind_i (kind_w),
        .cfg_i       (cfg_w),
        .mode_o      (mode_o),
        .clk_st_o    (clk_st_o),
        .fll_en_o    (fll_en_w),
        .pll_en_o    (pll_en_w),
        .irclk_en_o  (irclk_en_o)
    );

    assign clk_sel_o  = cfg_w.clk_sel;
    assign ref_st_o   = ref_st_w;
    assign pll_sten_o = cfg_w.pll_sten;
    assign fll_en_o   = fll_en_w;
    assign fll_lock_o = fll_lock_w;
    assign pll_en_o   = pll_en_w;
    assign pll_lock_o = pll_lock_w;

    // R5
    // stop_fll_quiet_chk
    stop_fll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop_w && $past(in_stop_w)) |-> !fll_lock_w);

    // R4
    // blp_pll_off_chk
    blp_pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode_q_w == M_BLPI) || (mode_q_w == M_BLPE)) && !in_stop_w) |=> !pll_lock_w);

endmodule

// File: tb/clkmode_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb;
    localparam int NSW  = 4;
    localparam int NLCK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] c_sel = 2'b00;
    logic       c_ref = 1'b1, c_lp = 1'b0, c_psel = 1'b0, c_clken = 1'b0;
    logic       c_psten = 1'b0, c_ien = 1'b0, c_isten = 1'b0, c_ifast = 1'b0;
    logic       stop_req = 1'b0;
    logic [1:0] stop_kind = 2'b00;
    logic       wake = 1'b0;
    logic       locked = 1'b1;
    logic [3:0] mode;
    logic [1:0] sel_o, st_o;
    logic       ref_st, psten_o, fll_en, fll_lock, pll_en, irclk_en, pll_lock, pll_lol;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    clkmode_ctrl #(.REF_SW_CYC(NSW), .FLL_LOCK_CYC(NLCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr),
        .cfg_clk_sel_i(c_sel), .cfg_ref_sel_i(c_ref), .cfg_lp_i(c_lp),
        .cfg_pll_sel_i(c_psel), .cfg_pll_clken_i(c_clken), .cfg_pll_sten_i(c_psten),
        .cfg_irc_en_i(c_ien), .cfg_irc_sten_i(c_isten), .cfg_irc_fast_i(c_ifast),
        .stop_req_i(stop_req), .stop_kind_i(stop_kind), .wake_i(wake),
        .pll_locked_i(locked),
        .mode_o(mode), .clk_sel_o(sel_o), .clk_st_o(st_o), .ref_st_o(ref_st),
        .pll_sten_o(psten_o), .fll_en_o(fll_en), .fll_lock_o(fll_lock),
        .pll_en_o(pll_en), .irclk_en_o(irclk_en), .pll_lock_o(pll_lock),
        .pll_lol_o(pll_lol)
    );

    // {sel[12:11], lp[10], pll_sel[9], clken[8], mode[7:4], st[3:2], fll[1], pll[0]}
    localparam logic [12:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 4'd0, 2'b00, 1'b1, 1'b0},
        {2'b01, 1'b0, 1'b0, 1'b0, 4'd2, 2'b01, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b1, 4'd4, 2'b01, 1'b0, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b0, 4'd3, 2'b10, 1'b1, 1'b0},
        {2'b10, 1'b1, 1'b1, 1'b1, 4'd5, 2'b10, 1'b0, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b0, 4'd6, 2'b10, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b1, 1'b0, 4'd8, 2'b11, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b1, 4'd0, 2'b00, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic rsel, input logic lp,
                      input logic psel, input logic clken, input logic psten,
                      input logic ien, input logic isten, input logic ifast);
        c_sel = sel; c_ref = rsel; c_lp = lp; c_psel = psel; c_clken = clken;
        c_psten = psten; c_ien = ien; c_isten = isten; c_ifast = ifast;
        cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic stop(input logic [1:0] kind);
        stop_kind = kind; stop_req = 1'b1;
        step(1);
        stop_req = 1'b0;
    endtask

    task automatic wakeup();
        wake = 1'b1;
        step(1);
        wake = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 sel", sel_o, 0);
        chk("R1 status", st_o, 0);
        chk("R1 ref_st", ref_st, 1);
        chk("R1 lock", pll_lock, 0);
        chk("R1 lol", pll_lol, 0);

        // R2 / R4 decode table with internal reference settled
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][12:11], 1'b1, VEC[i][10], VEC[i][9], VEC[i][8], 0, 0, 0, 0);
            step(1);
            chk("R2 mode", mode, VEC[i][7:4]);
            chk("R2 status", st_o, VEC[i][3:2]);
            chk("R4 fll_en", fll_en, VEC[i][1]);
            chk("R4 pll_en", pll_en, VEC[i][0]);
        end

        // R3 reference switch and FLL relock
        wr(2'b00, 1'b1, 0, 0, 0, 0, 0, 0, 0);
        step(NLCK + 4);
        chk("R3 fll lock before", fll_lock, 1);
        wr(2'b00, 1'b0, 0, 0, 0, 0, 0, 0, 0);
        step(NSW - 1);
        chk("R3 ref_st early", ref_st, 1);
        step(1);
        chk("R3 ref_st", ref_st, 0);
        chk("R3 fll relock start", fll_lock, 0);
        step(1);
        chk("R3 mode FEE", mode, 1);
        step(NLCK - 2);
        chk("R3 fll still relocking", fll_lock, 0);
        step(1);
        chk("R3 fll relocked", fll_lock, 1);

        // R9 normal stop from PEE with PLL stop-enable 1
        wr(2'b00, 1'b0, 0, 1, 0, 1, 1, 1, 0);
        step(3);
        chk("R2 mode PEE", mode, 7);
        chk("R2 status PLL", st_o, 3);
        chk("R11 lock", pll_lock, 1);
        stop(2'b00);
        chk("R5 mode STOP", mode, 9);
        chk("R5 fll off", fll_en, 0);
        chk("R5 pll kept", pll_en, 1);
        chk("R5 irc kept", irclk_en, 1);
        wr(2'b01, 1'b0, 0, 1, 0, 1, 1, 1, 0);
        chk("R10 write ignored", sel_o, 0);
        wakeup();
        chk("R9 stays PEE", mode, 7);
        chk("R9 lock kept", pll_lock, 1);
        chk("R9 lol", pll_lol, 0);

        // R9 normal stop from PEE with PLL stop-enable 0
        wr(2'b00, 1'b0, 0, 1, 0, 0, 1, 1, 0);
        step(2);
        stop(2'b00);
        chk("R5 pll gated", pll_en, 0);
        locked = 1'b0;
        step(2);
        locked = 1'b1;
        wakeup();
        chk("R9 forced PBE", mode, 6);
        chk("R9 sel", sel_o, 2);
        chk("R9 status", st_o, 2);
        chk("R9 lock cleared", pll_lock, 0);
        chk("R9 lol quiet", pll_lol, 0);

        // R7 LLS from PEE
        wr(2'b00, 1'b0, 0, 1, 0, 1, 1, 1, 0);
        step(3);
        chk("R7 PEE again", mode, 7);
        stop(2'b01);
        chk("R6 LLS pll off", pll_en, 0);
        chk("R6 LLS irc off", irclk_en, 0);
        chk("R6 LLS fll off", fll_en, 0);
        wakeup();
        chk("R7 mode", mode, 6);
        chk("R7 sel", sel_o, 2);
        chk("R7 status", st_o, 2);
        chk("R7 sten", psten_o, 0);
        chk("R7 lock", pll_lock, 0);
        chk("R7 lol", pll_lol, 0);

        // R6 VLPS internal reference needs the fast select
        wr(2'b10, 1'b0, 0, 1, 0, 0, 1, 1, 0);
        step(1);
        stop(2'b10);
        chk("R6 VLPS slow irc", irclk_en, 0);
        wakeup();
        chk("R6 resume PBE", mode, 6);
        wr(2'b10, 1'b0, 0, 1, 0, 0, 1, 1, 1);
        step(1);
        stop(2'b10);
        chk("R6 VLPS fast irc", irclk_en, 1);
        wakeup();

        // R10 stop request in stop and wake outside stop
        wr(2'b10, 1'b0, 0, 1, 0, 0, 1, 1, 0);
        step(1);
        stop(2'b00);
        chk("R5 normal irc", irclk_en, 1);
        stop(2'b10);
        chk("R10 second request ignored", irclk_en, 1);
        wakeup();
        wakeup();
        chk("R10 wake ignored", mode, 6);

        // R8 VLPS from PEI
        wr(2'b00, 1'b1, 0, 1, 0, 1, 0, 0, 0);
        step(NSW + 4);
        chk("R8 PEI", mode, 8);
        chk("R8 lock", pll_lock, 1);
        stop(2'b10);
        wakeup();
        chk("R8 sel", sel_o, 1);
        chk("R8 status", st_o, 1);
        chk("R8 mode FBI", mode, 2);
        chk("R8 sten", psten_o, 0);
        chk("R8 lock", pll_lock, 0);

        // R11 loss-of-lock is sticky
        wr(2'b10, 1'b1, 0, 1, 0, 0, 0, 0, 0);
        step(3);
        chk("R11 lock", pll_lock, 1);
        chk("R11 no lol", pll_lol, 0);
        locked = 1'b0;
        step(1);
        chk("R11 lol set", pll_lol, 1);
        chk("R11 lock drop", pll_lock, 0);
        locked = 1'b1;
        step(2);
        chk("R11 lol sticky", pll_lol, 1);
        chk("R11 relock", pll_lock, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule